// File: doc/BRIEF.md
# Byte-addressed word memory controller

This block connects a CPU port that addresses individual bytes to a synchronous RAM that is 32 bits wide. It turns byte, halfword and word requests into word-addressed RAM cycles with per-lane write enables. Reads are returned zero-extended in the low bits of the response word. Bytes are ordered big-endian: the byte at the lowest address is the most significant byte of the result.

A read that runs past the end of its aligned word can be handled in two ways. With `SPLIT_UNALIGNED` set, the block reads the aligned word that holds the first byte. It then reads the following word, wrapping at the top of the RAM, and joins the bytes it needs. With the parameter cleared, the request is refused with an error response. Unaligned writes are always refused and leave the RAM untouched.

The request side is a valid/ready stream. A request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high. The requester must hold its fields stable while valid is high and ready is low. `cpu_req_ready` stays low from acceptance until the response cycle has ended, so only one request is in flight at a time. The response side has no back-pressure: `cpu_rsp_valid` is high for exactly one cycle, and the requester must take the response in that cycle.

Top module: `bytemem_ctrl`

## Requirements
- R1: The RAM word address is `cpu_req_addr[ADDR_W-1:2]`. Byte offset k (address bits [1:0]) maps to RAM data bits [31-8k:24-8k] and to write enable bit `ram_we[3-k]`.
- R2: A request is accepted when valid and ready are both high. Ready is high only when the block is idle, and it is low during the response cycle.
- R3: Size encoding: 0 is byte, 1 is halfword, 2 is word. A byte read returns the byte in `cpu_rsp_rdata[7:0]`. A halfword read returns the byte at the request address in [15:8] and the next byte in [7:0]. All unused upper bits are zero.
- R4: A write drives `ram_wdata` and enables exactly the addressed lanes: one lane for a byte, two for a halfword, four for a word. The data is taken from the low bits of `cpu_req_wdata`.
- R5: An access is unaligned when its byte offset plus its size in bytes exceeds 4. This covers a halfword at offset 3 and a word at offsets 1 to 3.
- R6: In split mode, an unaligned read issues word address W and then W+1, wrapping at the top of the RAM. It merges the bytes big-endian. For example, if bytes 0 to 7 hold 0x01 to 0x08, a word read at address 1 returns 0x02030405.
- R7: An aligned access responds one cycle after acceptance. A split read responds two cycles after acceptance.
- R8: `cpu_rsp_valid` is high for exactly one cycle per accepted request. `cpu_rsp_err` is meaningful only in that cycle.
- R9: An unaligned write performs no RAM access and responds with the error flag set and read data zero.
- R10: With `SPLIT_UNALIGNED` cleared, every unaligned read or write responds with the error flag set and makes no RAM access. Aligned accesses work as in split mode.
- R11: After reset the block is idle: ready is high, no response is valid, and the RAM is not enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Request valid |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Write data, low-justified |
| cpu_rsp_valid | output | 1 | Response valid, one cycle |
| cpu_rsp_rdata | output | DATA_W | Read data, low-justified and zero-extended |
| cpu_rsp_err | output | 1 | Misaligned access refused |
| ram_en | output | 1 | RAM access enable |
| ram_addr | output | ADDR_W-2 | RAM word address |
| ram_we | output | DATA_W/8 | Per-lane write enables |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after an enabled read |

## Verification
The assertions assume the following about the inputs:
- The RAM returns read data one cycle after an enabled cycle and holds it while not enabled.
- `cpu_req_size` never carries the value 3.
- Request fields stay stable while valid waits for ready.

The stimulus meets these assumptions:
- The bench models the RAM with exactly that one-cycle latency.
- It drives only the three defined sizes.
- It raises valid only on a falling edge while the block is idle and drops it after the accepting edge.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SECOND = 2'd1,
    ST_RESP   = 2'd2
  } ctl_state_e;

  // number of bytes moved by a size code; unused code 3 is taken as a word
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/bmc_write_lanes.sv
module bmc_write_lanes
  import bmc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
)(
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] lane_data
);

  int unsigned nbytes;
  logic [DATA_W-1:0] top_just;

  assign nbytes = size_bytes(size);

  // move the low-justified value to the top, then down to its lane offset
  always_comb begin
    top_just  = wdata << (8 * (LANES - nbytes));
    lane_data = top_just >> (8 * off);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_we[LANES-1-k] = (k >= int'(off)) && (k < int'(off) + int'(nbytes));
  end

  // R4: an access that fits in the word enables exactly as many lanes as it has bytes
  always_comb begin
    if (!$isunknown({size, off}) && (int'(off) + int'(nbytes) <= LANES)) begin
      a_r4_lane_count: assert ($countones(lane_we) == nbytes);
    end
  end

endmodule

// File: rtl/bmc_read_merge.sv
module bmc_read_merge
  import bmc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
)(
  input  logic              split,
  input  logic [DATA_W-1:0] first_word,
  input  logic [DATA_W-1:0] last_word,
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] rdata
);

  int unsigned nbytes;
  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] window;
  logic [DATA_W-1:0]   top_bytes;

  assign nbytes = size_bytes(size);

  // big-endian pair of words; the wanted bytes start 'off' bytes from the top
  always_comb begin
    joined    = split ? {first_word, last_word} : {last_word, {DATA_W{1'b0}}};
    window    = joined << (8 * off);
    top_bytes = window[2*DATA_W-1:DATA_W];
    rdata     = top_bytes >> (8 * (LANES - nbytes));
  end

endmodule

// File: rtl/bytemem_ctrl.sv
module bytemem_ctrl
  import bmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter bit SPLIT_UNALIGNED = 1'b1,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int WA_W  = ADDR_W - OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [1:0]        cpu_req_size,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_err,
  output logic              ram_en,
  output logic [WA_W-1:0]   ram_addr,
  output logic [LANES-1:0]  ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  ctl_state_e state_q;

  logic [OFF_W-1:0]  req_off;
  logic [WA_W-1:0]   req_waddr;
  logic              accept, crosses, do_split, refuse;
  logic [LANES-1:0]  lane_we;

  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              split_q, err_q, wr_q;
  logic [WA_W-1:0]   next_waddr_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] merged;

  assign req_off   = cpu_req_addr[OFF_W-1:0];
  assign req_waddr = cpu_req_addr[ADDR_W-1:OFF_W];

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign crosses       = (int'(req_off) + int'(size_bytes(cpu_req_size))) > LANES;
  assign do_split      = SPLIT_UNALIGNED && !cpu_req_write && crosses;
  assign refuse        = crosses && !do_split;

  bmc_write_lanes #(.DATA_W(DATA_W)) u_lanes (
    .size      (cpu_req_size),
    .off       (req_off),
    .wdata     (cpu_req_wdata),
    .lane_we   (lane_we),
    .lane_data (ram_wdata)
  );

  // RAM side: the first access goes out in the accepting cycle, the second from ST_SECOND
  assign ram_en   = (accept && !refuse) || (state_q == ST_SECOND);
  assign ram_addr = (state_q == ST_SECOND) ? next_waddr_q : req_waddr;
  assign ram_we   = (accept && cpu_req_write && !refuse) ? lane_we : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      off_q        <= '0;
      size_q       <= '0;
      split_q      <= 1'b0;
      err_q        <= 1'b0;
      wr_q         <= 1'b0;
      next_waddr_q <= '0;
      hold_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          off_q        <= req_off;
          size_q       <= cpu_req_size;
          split_q      <= do_split;
          err_q        <= refuse;
          wr_q         <= cpu_req_write;
          next_waddr_q <= req_waddr + 1'b1;
          state_q      <= do_split ? ST_SECOND : ST_RESP;
        end
        ST_SECOND: begin
          hold_q  <= ram_rdata;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  bmc_read_merge #(.DATA_W(DATA_W)) u_merge (
    .split      (split_q),
    .first_word (hold_q),
    .last_word  (ram_rdata),
    .size       (size_q),
    .off        (off_q),
    .rdata      (merged)
  );

  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_err   = err_q;
  assign cpu_rsp_rdata = (err_q || wr_q) ? '0 : merged;

  // R8: a response lasts one cycle
  a_r8_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R2: no new request is taken while a response is presented
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

  // R6: the second read of a split targets the following word, wrapping
  a_r6_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SECOND) |-> (ram_en && ram_addr == WA_W'($past(ram_addr) + 1'b1)));

  // R9 / R10: a refused access never touched the RAM
  a_r9_refused_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && cpu_rsp_err) |-> !$past(ram_en));

endmodule

// File: tb/bytemem_ctrl_bench.sv
module bytemem_ctrl_bench;

  localparam int AW = 6;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // split-mode DUT (a_) and strict DUT (b_)
  logic        a_valid = 0, a_ready, a_write = 0, a_rsp_valid, a_err, a_ram_en;
  logic [1:0]  a_size = 0;
  logic [AW-1:0] a_addr = 0;
  logic [31:0] a_wdata = 0, a_rdata, a_ram_wdata, a_ram_rdata = 0;
  logic [AW-3:0] a_ram_addr;
  logic [3:0]  a_ram_we;

  logic        b_valid = 0, b_ready, b_write = 0, b_rsp_valid, b_err, b_ram_en;
  logic [1:0]  b_size = 0;
  logic [AW-1:0] b_addr = 0;
  logic [31:0] b_wdata = 0, b_rdata, b_ram_wdata, b_ram_rdata = 0;
  logic [AW-3:0] b_ram_addr;
  logic [3:0]  b_ram_we;

  bytemem_ctrl #(.ADDR_W(AW), .DATA_W(32), .SPLIT_UNALIGNED(1'b1)) u_bytemem_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(a_valid), .cpu_req_ready(a_ready), .cpu_req_write(a_write),
    .cpu_req_size(a_size), .cpu_req_addr(a_addr), .cpu_req_wdata(a_wdata),
    .cpu_rsp_valid(a_rsp_valid), .cpu_rsp_rdata(a_rdata), .cpu_rsp_err(a_err),
    .ram_en(a_ram_en), .ram_addr(a_ram_addr), .ram_we(a_ram_we),
    .ram_wdata(a_ram_wdata), .ram_rdata(a_ram_rdata)
  );

  bytemem_ctrl #(.ADDR_W(AW), .DATA_W(32), .SPLIT_UNALIGNED(1'b0)) u_strict (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(b_valid), .cpu_req_ready(b_ready), .cpu_req_write(b_write),
    .cpu_req_size(b_size), .cpu_req_addr(b_addr), .cpu_req_wdata(b_wdata),
    .cpu_rsp_valid(b_rsp_valid), .cpu_rsp_rdata(b_rdata), .cpu_rsp_err(b_err),
    .ram_en(b_ram_en), .ram_addr(b_ram_addr), .ram_we(b_ram_we),
    .ram_wdata(b_ram_wdata), .ram_rdata(b_ram_rdata)
  );

  // shared byte-array RAM, big-endian lanes, one-cycle read latency
  logic [7:0] mem [NB];
  logic [7:0] ref_mem [NB];

  always @(posedge clk) begin
    if (a_ram_en) begin
      for (int k = 0; k < 4; k++)
        if (a_ram_we[3-k]) mem[{a_ram_addr, 2'(k)}] <= a_ram_wdata[31-8*k -: 8];
      a_ram_rdata <= {mem[{a_ram_addr, 2'd0}], mem[{a_ram_addr, 2'd1}],
                      mem[{a_ram_addr, 2'd2}], mem[{a_ram_addr, 2'd3}]};
    end
    if (b_ram_en) begin
      for (int k = 0; k < 4; k++)
        if (b_ram_we[3-k]) mem[{b_ram_addr, 2'(k)}] <= b_ram_wdata[31-8*k -: 8];
      b_ram_rdata <= {mem[{b_ram_addr, 2'd0}], mem[{b_ram_addr, 2'd1}],
                      mem[{b_ram_addr, 2'd2}], mem[{b_ram_addr, 2'd3}]};
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ref_read(input logic [1:0] sz, input int ad);
    logic [31:0] v = 0;
    for (int j = 0; j < nb_of(sz); j++) v = (v << 8) | 32'(ref_mem[(ad + j) % NB]);
    return v;
  endfunction

  task automatic ref_write(input logic [1:0] sz, input int ad, input logic [31:0] wd);
    for (int j = 0; j < nb_of(sz); j++)
      ref_mem[(ad + j) % NB] = wd[8*(nb_of(sz)-1-j) +: 8];
  endtask

  task automatic do_req(input bit strict, input bit wr, input logic [1:0] sz,
                        input logic [AW-1:0] ad, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output int lat);
    @(negedge clk);
    if (strict) begin b_valid = 1; b_write = wr; b_size = sz; b_addr = ad; b_wdata = wd; end
    else        begin a_valid = 1; a_write = wr; a_size = sz; a_addr = ad; a_wdata = wd; end
    @(posedge clk);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    lat = 1;
    while (!(strict ? b_rsp_valid : a_rsp_valid) && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    rd = strict ? b_rdata : a_rdata;
    er = strict ? b_err : a_err;
    check("R2 ready low in response", 32'(strict ? b_ready : a_ready), 32'd0);
  endtask

  typedef struct packed {
    logic          wr;
    logic [1:0]    sz;
    logic [AW-1:0] ad;
    logic [31:0]   wd;
    logic [31:0]   exp;
    logic          err;
    logic [1:0]    lat;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{1'b0, 2'd2, 6'd0,  32'h0,        32'h01020304, 1'b0, 2'd1},  // R3 aligned word
    '{1'b0, 2'd2, 6'd1,  32'h0,        32'h02030405, 1'b0, 2'd2},  // R6 merge example
    '{1'b0, 2'd0, 6'd2,  32'h0,        32'h00000003, 1'b0, 2'd1},  // R3 byte
    '{1'b0, 2'd1, 6'd2,  32'h0,        32'h00000304, 1'b0, 2'd1},  // R3 half
    '{1'b0, 2'd1, 6'd3,  32'h0,        32'h00000405, 1'b0, 2'd2},  // R5 half at 3 splits
    '{1'b0, 2'd2, 6'd3,  32'h0,        32'h04050607, 1'b0, 2'd2},  // R6
    '{1'b0, 2'd2, 6'd61, 32'h0,        32'h3E3F4001, 1'b0, 2'd2},  // R6 wrap
    '{1'b1, 2'd0, 6'd5,  32'h000000AA, 32'h0,        1'b0, 2'd1},  // R4 byte write
    '{1'b0, 2'd2, 6'd4,  32'h0,        32'h05AA0708, 1'b0, 2'd1},  // R4
    '{1'b1, 2'd1, 6'd6,  32'h0000BEEF, 32'h0,        1'b0, 2'd1},  // R4 half write
    '{1'b0, 2'd2, 6'd4,  32'h0,        32'h05AABEEF, 1'b0, 2'd1},  // R4
    '{1'b1, 2'd2, 6'd9,  32'h12345678, 32'h0,        1'b1, 2'd1},  // R9
    '{1'b0, 2'd2, 6'd8,  32'h0,        32'h090A0B0C, 1'b0, 2'd1},  // R9 unchanged
    '{1'b1, 2'd1, 6'd11, 32'h00001111, 32'h0,        1'b1, 2'd1},  // R9 half at 3
    '{1'b0, 2'd2, 6'd11, 32'h0,        32'h0C0D0E0F, 1'b0, 2'd2},  // R9 unchanged
    '{1'b1, 2'd2, 6'd8,  32'hCAFEF00D, 32'h0,        1'b0, 2'd1},  // R4 word write
    '{1'b0, 2'd0, 6'd9,  32'h0,        32'h000000FE, 1'b0, 2'd1},  // R3
    '{1'b0, 2'd1, 6'd7,  32'h0,        32'h0000EFCA, 1'b0, 2'd2}   // R6 after writes
  };

  logic [31:0] rd;
  logic        er;
  int          lat;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mem[i] = 8'(i + 1);
      ref_mem[i] = 8'(i + 1);
    end
    repeat (3) @(negedge clk);
    // R11: idle after reset
    check("R11 ready", 32'(a_ready), 32'd1);
    check("R11 rsp_valid", 32'(a_rsp_valid), 32'd0);
    check("R11 ram_en", 32'(a_ram_en), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 18; v++) begin
      do_req(1'b0, VECS[v].wr, VECS[v].sz, VECS[v].ad, VECS[v].wd, rd, er, lat);
      check($sformatf("R3/R6 vec %0d data", v), rd, VECS[v].exp);
      check($sformatf("R9 vec %0d err", v), 32'(er), 32'(VECS[v].err));
      check($sformatf("R7 vec %0d latency", v), 32'(lat), 32'(VECS[v].lat));
      if (VECS[v].wr && !VECS[v].err) ref_write(VECS[v].sz, int'(VECS[v].ad), VECS[v].wd);
    end

    // R1 / R4: RAM-side mapping observed in the accepting cycle
    @(negedge clk);
    a_valid = 1; a_write = 1; a_size = 2'd0; a_addr = 6'd45; a_wdata = 32'h5A;
    #1;
    check("R1 word address", 32'(a_ram_addr), 32'd11);
    check("R1 lane 1 enable", 32'(a_ram_we), 32'h4);
    check("R4 lane data", a_ram_wdata, 32'h005A0000);
    @(posedge clk);
    @(negedge clk);
    a_valid = 0;
    ref_write(2'd0, 45, 32'h5A);
    @(negedge clk);

    // R5 / R6 / R9: every size and offset against the byte-array model
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off++) begin
        bit unal;
        unal = (off + nb_of(2'(sz))) > 4;
        do_req(1'b0, 1'b0, 2'(sz), 6'(16 + off), 32'h0, rd, er, lat);
        check($sformatf("R6 read sz%0d off%0d", sz, off), rd, ref_read(2'(sz), 16 + off));
        check($sformatf("R7 read lat sz%0d off%0d", sz, off), 32'(lat), unal ? 32'd2 : 32'd1);
        do_req(1'b0, 1'b1, 2'(sz), 6'(32 + off), 32'hA1B2C3D4 ^ 32'(off), rd, er, lat);
        check($sformatf("R5 write err sz%0d off%0d", sz, off), 32'(er), 32'(unal));
        if (!unal) ref_write(2'(sz), 32 + off, 32'hA1B2C3D4 ^ 32'(off));
        do_req(1'b0, 1'b0, 2'd2, 6'd32, 32'h0, rd, er, lat);
        check("R9 readback w8", rd, ref_read(2'd2, 32));
        do_req(1'b0, 1'b0, 2'd2, 6'd36, 32'h0, rd, er, lat);
        check("R9 readback w9", rd, ref_read(2'd2, 36));
      end
    end

    // R10: strict mode refuses unaligned reads and writes
    do_req(1'b1, 1'b0, 2'd2, 6'd1, 32'h0, rd, er, lat);
    check("R10 strict word@1 err", 32'(er), 32'd1);
    check("R10 strict word@1 data", rd, 32'h0);
    do_req(1'b1, 1'b0, 2'd1, 6'd3, 32'h0, rd, er, lat);
    check("R10 strict half@3 err", 32'(er), 32'd1);
    do_req(1'b1, 1'b0, 2'd2, 6'd0, 32'h0, rd, er, lat);
    check("R10 strict aligned data", rd, ref_read(2'd2, 0));
    check("R10 strict aligned err", 32'(er), 32'd0);
    do_req(1'b1, 1'b1, 2'd2, 6'd41, 32'hDEADBEEF, rd, er, lat);
    check("R10 strict write err", 32'(er), 32'd1);
    do_req(1'b0, 1'b0, 2'd2, 6'd40, 32'h0, rd, er, lat);
    check("R10 strict write left memory", rd, ref_read(2'd2, 40));

    // R8: response gone in the following cycle
    @(negedge clk);
    check("R8 response single cycle", 32'(a_rsp_valid), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule